// File: doc/BRIEF.md
# Three-Operand Multiply-Accumulate Execute Unit

This unit takes one 32-bit word from the three-source data-processing group of a 64-bit instruction set and executes it. The group covers multiply-add and multiply-subtract in 32-bit and 64-bit widths, widening multiply-add and multiply-subtract on the low 32 bits of each multiplicand (signed or unsigned), and the upper half of a full 128-bit product (signed or unsigned). The surrounding pipeline reads three 64-bit operands from its register file and presents them with the word. The unit returns the destination index, the 64-bit result, a write-enable and an undefined-instruction flag. Condition flags are never touched.

Requests use a valid/ready handshake. One operation is in flight at a time. The response appears a fixed, parameterised number of cycles after acceptance. Register index 31 is the zero register: as a source it reads as zero, and as a destination the write is dropped.

Top module: `mac3_exec_unit`

## Requirements
- R1: The 7-bit operation code is {bit 31, bits 30:29, bits 23:21, bit 15}, with bit 15 as its LSB. Only codes 0x00, 0x01, 0x40, 0x41, 0x42, 0x43, 0x44, 0x4A, 0x4B and 0x4C are legal, and only when bits 28:24 equal 11011. Any other word gives rsp_undef=1, rsp_wr_en=0 and rsp_data=0.
- R2: Codes 0x40 (add) and 0x41 (subtract) return acc + a*b or acc - a*b modulo 2^64. Code bit 0 selects the subtract.
- R3: When bit 31 is 0 (codes 0x00 and 0x01), the add or subtract result is cut to its low 32 bits and zero-extended to 64 bits.
- R4: Codes 0x42 and 0x43 sign-extend the low 32 bits of each multiplicand before the multiply. Codes 0x4A and 0x4B zero-extend them. The accumulate then follows R2.
- R5: Code 0x44 (signed) and code 0x4C (unsigned) return bits 127:64 of the full 128-bit product of the two 64-bit multiplicands. The accumulator operand has no effect on these codes.
- R6: A source field equal to 31 reads as zero. The multiplicand fields are bits 9:5 and 20:16, and the accumulator field is bits 14:10. So an add whose accumulator field is 31 returns the plain product.
- R7: rsp_dest equals bits 4:0. When it is 31, rsp_wr_en is 0. rsp_wr_en is never high without rsp_valid.
- R8: rsp_valid is high for exactly one cycle, LATENCY cycles after the cycle in which req_valid and req_ready were both high.
- R9: req_ready is low from the cycle after an acceptance up to the response cycle. A request presented while req_ready is low is not taken and produces no response.
- R10: After reset, req_ready is 1, rsp_valid is 0 and rsp_wr_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_insn | input | 32 | Instruction word |
| req_mul_a | input | XLEN | Value of the register named by bits 9:5 |
| req_mul_b | input | XLEN | Value of the register named by bits 20:16 |
| req_acc | input | XLEN | Value of the register named by bits 14:10 |
| rsp_valid | output | 1 | Response present |
| rsp_dest | output | 5 | Destination register index |
| rsp_data | output | XLEN | Result value |
| rsp_wr_en | output | 1 | Write the result to rsp_dest |
| rsp_undef | output | 1 | Word is not a legal member of the group |

## Verification
Take the cycle in which a request is accepted as cycle 0. Then req_ready must be low in cycles 1 to LATENCY-1, and rsp_valid must be low there too. The response fields are due only in cycle LATENCY, and rsp_valid must be low again afterwards. The bench samples at the falling edge of every one of these cycles, so each check falls on the one cycle the requirement names and not merely somewhere in a window. Result values are compared against a 128-bit arithmetic model built from the requirements. The model covers every legal code, a sample of illegal codes and corner operands, and the model alone fixes the expected destination, write-enable and undefined flag.

// File: rtl/mac3_pkg.sv
package mac3_pkg;

  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam logic [IDX_W-1:0] ZERO_IDX  = '1;
  localparam logic [4:0]       GROUP_TAG = 5'b11011;

  // legal operation codes {bit31, bits30:29, bits23:21, bit15}
  typedef enum logic [6:0] {
    OP_MADD_W = 7'h00,
    OP_MSUB_W = 7'h01,
    OP_MADD_X = 7'h40,
    OP_MSUB_X = 7'h41,
    OP_SWADD  = 7'h42,
    OP_SWSUB  = 7'h43,
    OP_SHIGH  = 7'h44,
    OP_UWADD  = 7'h4A,
    OP_UWSUB  = 7'h4B,
    OP_UHIGH  = 7'h4C
  } opsel_e;

  // control that travels down the pipe to the output stage
  typedef struct packed {
    logic [IDX_W-1:0] dest;
    logic             wr;
    logic             undef;
    logic             sub;
    logic             high;
    logic             narrow;
  } tail_t;

  typedef struct packed {
    tail_t tail;
    logic  sgn;
    logic  wide;
  } ctl_t;

endpackage

// File: rtl/mac3_decode.sv
module mac3_decode
  import mac3_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output ctl_t              ctl,
  output logic [IDX_W-1:0]  idx_mul_a,
  output logic [IDX_W-1:0]  idx_mul_b,
  output logic [IDX_W-1:0]  idx_acc
);

  logic [6:0] code;
  logic       code_ok;
  logic       code_sgn;
  logic       legal;

  assign idx_mul_a = insn[9:5];
  assign idx_mul_b = insn[20:16];
  assign idx_acc   = insn[14:10];

  always_comb begin
    code     = {insn[31], insn[30:29], insn[23:21], insn[15]};
    code_ok  = 1'b0;
    code_sgn = 1'b0;
    case (code)
      OP_MADD_W, OP_MSUB_W, OP_MADD_X, OP_MSUB_X,
      OP_UWADD, OP_UWSUB, OP_UHIGH: code_ok = 1'b1;
      OP_SWADD, OP_SWSUB, OP_SHIGH: begin
        code_ok  = 1'b1;
        code_sgn = 1'b1;
      end
      default: code_ok = 1'b0;
    endcase
    legal = code_ok & (insn[28:24] == GROUP_TAG);
  end

  always_comb begin
    ctl.tail.dest   = insn[4:0];
    ctl.tail.wr     = legal & (insn[4:0] != ZERO_IDX);
    ctl.tail.undef  = ~legal;
    ctl.tail.sub    = legal & code[0];
    ctl.tail.high   = legal & code[2];
    ctl.tail.narrow = legal & ~code[6];
    ctl.sgn         = legal & code_sgn;
    ctl.wide        = legal & code[6] & code[1];
  end

  always_comb begin
    if (legal) begin
      AST_DECODE_HIGH_NOT_WIDE: assert (!(ctl.tail.high && ctl.wide)); // R5
    end
  end

endmodule

// File: rtl/mac3_operand_prep.sv
module mac3_operand_prep
  import mac3_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IDX_W-1:0] idx_mul_a,
  input  logic [IDX_W-1:0] idx_mul_b,
  input  logic [IDX_W-1:0] idx_acc,
  input  logic [XLEN-1:0]  raw_mul_a,
  input  logic [XLEN-1:0]  raw_mul_b,
  input  logic [XLEN-1:0]  raw_acc,
  input  logic             wide,
  input  logic             sgn,
  input  logic             high,
  output logic [XLEN-1:0]  op_a,
  output logic [XLEN-1:0]  op_b,
  output logic [XLEN-1:0]  acc
);

  localparam int HALF = XLEN / 2;
  localparam int NSRC = 3;

  logic [IDX_W-1:0] src_idx [NSRC];
  logic [XLEN-1:0]  src_raw [NSRC];
  logic [XLEN-1:0]  src_val [NSRC];

  assign src_idx[0] = idx_mul_a;
  assign src_idx[1] = idx_mul_b;
  assign src_idx[2] = idx_acc;
  assign src_raw[0] = raw_mul_a;
  assign src_raw[1] = raw_mul_b;
  assign src_raw[2] = raw_acc;

  // index 31 is the zero register on every read port
  for (genvar g = 0; g < NSRC; g++) begin : g_zero_reg
    assign src_val[g] = (src_idx[g] == ZERO_IDX) ? '0 : src_raw[g];
  end

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v, input logic s);
    return {{HALF{s & v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  assign op_a = wide ? widen(src_val[0], sgn) : src_val[0];
  assign op_b = wide ? widen(src_val[1], sgn) : src_val[1];
  assign acc  = high ? '0 : src_val[2];

  always_comb begin
    if (wide) begin
      AST_WIDE_UPPER_EXT: assert (op_a[XLEN-1:HALF] == {HALF{sgn & op_a[HALF-1]}}); // R4
    end
  end

endmodule

// File: rtl/mac3_mul_pipe.sv
module mac3_mul_pipe
  import mac3_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  tail_t            in_tail,
  input  logic             in_sgn,
  input  logic [XLEN-1:0]  in_op_a,
  input  logic [XLEN-1:0]  in_op_b,
  input  logic [XLEN-1:0]  in_acc,
  output logic             out_valid,
  output logic             out_wr,
  output logic             out_undef,
  output logic [IDX_W-1:0] out_dest,
  output logic [XLEN-1:0]  out_data,
  output logic             busy
);

  localparam int PW   = 2 * XLEN;
  localparam int HALF = XLEN / 2;
  localparam int NCH  = LATENCY - 2;

  // stage 0: operands captured at acceptance
  logic            s0_valid;
  tail_t           s0_tail;
  logic            s0_sgn;
  logic [XLEN-1:0] s0_a;
  logic [XLEN-1:0] s0_b;
  logic [XLEN-1:0] s0_acc;

  always_ff @(posedge clk) begin
    if (rst) s0_valid <= 1'b0;
    else     s0_valid <= in_valid;
    if (in_valid) begin
      s0_tail <= in_tail;
      s0_sgn  <= in_sgn;
      s0_a    <= in_op_a;
      s0_b    <= in_op_b;
      s0_acc  <= in_acc;
    end
  end

  // one full-width product serves both the low and the high forms
  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;
  logic [PW-1:0] s0_prod;

  assign ext_a   = {{XLEN{s0_sgn & s0_a[XLEN-1]}}, s0_a};
  assign ext_b   = {{XLEN{s0_sgn & s0_b[XLEN-1]}}, s0_b};
  assign s0_prod = ext_a * ext_b;

  logic            end_vld;
  tail_t           end_tail;
  logic [PW-1:0]   end_prod;
  logic [XLEN-1:0] end_acc;

  if (NCH == 0) begin : g_direct
    assign end_vld  = s0_valid;
    assign end_tail = s0_tail;
    assign end_prod = s0_prod;
    assign end_acc  = s0_acc;
    assign busy     = s0_valid;
  end else begin : g_chain
    logic [NCH-1:0]           ch_vld;
    tail_t [NCH-1:0]          ch_tail;
    logic [NCH-1:0][PW-1:0]   ch_prod;
    logic [NCH-1:0][XLEN-1:0] ch_acc;

    always_ff @(posedge clk) begin
      if (rst) ch_vld <= '0;
      else begin
        ch_vld[0] <= s0_valid;
        for (int i = 1; i < NCH; i++) ch_vld[i] <= ch_vld[i-1];
      end
      ch_tail[0] <= s0_tail;
      ch_prod[0] <= s0_prod;
      ch_acc[0]  <= s0_acc;
      for (int i = 1; i < NCH; i++) begin
        ch_tail[i] <= ch_tail[i-1];
        ch_prod[i] <= ch_prod[i-1];
        ch_acc[i]  <= ch_acc[i-1];
      end
    end

    assign end_vld  = ch_vld[NCH-1];
    assign end_tail = ch_tail[NCH-1];
    assign end_prod = ch_prod[NCH-1];
    assign end_acc  = ch_acc[NCH-1];
    assign busy     = s0_valid | (|ch_vld);
  end

  // final combine: accumulate, select half, narrow, squash
  logic [XLEN-1:0] prod_lo;
  logic [XLEN-1:0] prod_hi;
  logic [XLEN-1:0] accum;
  logic [XLEN-1:0] result;

  always_comb begin
    prod_lo = end_prod[XLEN-1:0];
    prod_hi = end_prod[PW-1:XLEN];
    accum   = end_tail.sub ? (end_acc - prod_lo) : (end_acc + prod_lo);
    result  = end_tail.high ? prod_hi : accum;
    if (end_tail.narrow) result = {{HALF{1'b0}}, result[HALF-1:0]};
    if (end_tail.undef)  result = '0;
  end

  logic out_narrow;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wr     <= 1'b0;
      out_undef  <= 1'b0;
      out_narrow <= 1'b0;
      out_dest   <= '0;
      out_data   <= '0;
    end else begin
      out_valid  <= end_vld;
      out_wr     <= end_vld & end_tail.wr;
      out_undef  <= end_vld & end_tail.undef;
      out_narrow <= end_vld & end_tail.narrow;
      out_dest   <= end_tail.dest;
      out_data   <= result;
    end
  end

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_narrow |-> out_data[XLEN-1:HALF] == '0); // R3
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_undef |-> !out_wr && out_data == '0); // R1
  AST_DEST31_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_dest == ZERO_IDX |-> !out_wr); // R7

endmodule

// File: rtl/mac3_exec_unit.sv
module mac3_exec_unit
  import mac3_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [INSN_W-1:0] req_insn,
  input  logic [XLEN-1:0]   req_mul_a,
  input  logic [XLEN-1:0]   req_mul_b,
  input  logic [XLEN-1:0]   req_acc,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_dest,
  output logic [XLEN-1:0]   rsp_data,
  output logic              rsp_wr_en,
  output logic              rsp_undef
);

  localparam int AGE_W = $clog2(LATENCY + 2) + 1;

  ctl_t             ctl;
  logic [IDX_W-1:0] idx_mul_a;
  logic [IDX_W-1:0] idx_mul_b;
  logic [IDX_W-1:0] idx_acc;
  logic [XLEN-1:0]  op_a;
  logic [XLEN-1:0]  op_b;
  logic [XLEN-1:0]  op_acc;
  logic             busy;
  logic             accept;

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  mac3_decode u_decode (
    .insn      (req_insn),
    .ctl       (ctl),
    .idx_mul_a (idx_mul_a),
    .idx_mul_b (idx_mul_b),
    .idx_acc   (idx_acc)
  );

  mac3_operand_prep #(.XLEN(XLEN)) u_prep (
    .idx_mul_a (idx_mul_a),
    .idx_mul_b (idx_mul_b),
    .idx_acc   (idx_acc),
    .raw_mul_a (req_mul_a),
    .raw_mul_b (req_mul_b),
    .raw_acc   (req_acc),
    .wide      (ctl.wide),
    .sgn       (ctl.sgn),
    .high      (ctl.tail.high),
    .op_a      (op_a),
    .op_b      (op_b),
    .acc       (op_acc)
  );

  mac3_mul_pipe #(.XLEN(XLEN), .LATENCY(LATENCY)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (accept),
    .in_tail   (ctl.tail),
    .in_sgn    (ctl.sgn),
    .in_op_a   (op_a),
    .in_op_b   (op_b),
    .in_acc    (op_acc),
    .out_valid (rsp_valid),
    .out_wr    (rsp_wr_en),
    .out_undef (rsp_undef),
    .out_dest  (rsp_dest),
    .out_data  (rsp_data),
    .busy      (busy)
  );

  // cycles since the last acceptance, for the latency check only
  logic [AGE_W-1:0] ast_age;

  always_ff @(posedge clk) begin
    if (rst)                 ast_age <= '0;
    else if (accept)         ast_age <= AGE_W'(1);
    else if (ast_age != '1)  ast_age <= ast_age + AGE_W'(1);
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ast_age == AGE_W'(LATENCY)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R9
  AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_wr_en |-> rsp_valid); // R7

endmodule

// File: tb/mac3_exec_unit_tb.sv
module mac3_exec_unit_tb_top;

  localparam int XLEN = 64;
  localparam int LAT  = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [31:0]     req_insn = '0;
  logic [XLEN-1:0] req_mul_a = '0;
  logic [XLEN-1:0] req_mul_b = '0;
  logic [XLEN-1:0] req_acc = '0;
  logic            rsp_valid;
  logic [4:0]      rsp_dest;
  logic [XLEN-1:0] rsp_data;
  logic            rsp_wr_en;
  logic            rsp_undef;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mac3_exec_unit #(.XLEN(XLEN), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_insn(req_insn),
    .req_mul_a(req_mul_a), .req_mul_b(req_mul_b), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_data(rsp_data),
    .rsp_wr_en(rsp_wr_en), .rsp_undef(rsp_undef)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] code, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [4:0] rc);
    return {code[6], code[5:4], 5'b11011, code[3:1], rb, code[0], rc, ra, rd};
  endfunction

  // model built from the requirements: {undef, wr, data}
  function automatic logic [65:0] ref_model(input logic [31:0] w, input logic [63:0] xa,
                                            input logic [63:0] xb, input logic [63:0] xc);
    logic [6:0] code;
    logic [63:0] a, b, c, lo, r;
    logic signed [127:0] sa, sb, sp;
    logic [127:0] up;
    bit legal;
    code = {w[31], w[30:29], w[23:21], w[15]};
    a = (w[9:5]   == 5'd31) ? 64'd0 : xa;
    b = (w[20:16] == 5'd31) ? 64'd0 : xb;
    c = (w[14:10] == 5'd31) ? 64'd0 : xc;
    legal = (w[28:24] == 5'b11011) &&
            (code == 7'h00 || code == 7'h01 || code == 7'h40 || code == 7'h41 ||
             code == 7'h42 || code == 7'h43 || code == 7'h44 || code == 7'h4A ||
             code == 7'h4B || code == 7'h4C);
    if (!legal) return {1'b1, 1'b0, 64'd0};
    if (code == 7'h44) begin
      sa = $signed({{64{a[63]}}, a});
      sb = $signed({{64{b[63]}}, b});
      sp = sa * sb;
      r  = sp[127:64];
    end else if (code == 7'h4C) begin
      up = {64'd0, a} * {64'd0, b};
      r  = up[127:64];
    end else begin
      if (code == 7'h42 || code == 7'h43)
        lo = {{32{a[31]}}, a[31:0]} * {{32{b[31]}}, b[31:0]};
      else if (code == 7'h4A || code == 7'h4B)
        lo = {32'd0, a[31:0]} * {32'd0, b[31:0]};
      else
        lo = a * b;
      r = code[0] ? (c - lo) : (c + lo);
      if (!w[31]) r = {32'd0, r[31:0]};
    end
    return {1'b0, (w[4:0] != 5'd31), r};
  endfunction

  // drive one request, check timing cycle by cycle and the response fields
  task automatic run_op(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input string req);
    logic [65:0] e;
    e = ref_model(w, a, b, c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_insn = w; req_mul_a = a; req_mul_b = b; req_acc = c;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready after accept", 64'(req_ready), 64'd0);
      end
      if (k < LAT) begin
        chk(rsp_valid == 1'b0, "R8", "early valid", 64'(rsp_valid), 64'd0);
      end else begin
        chk(rsp_valid == 1'b1, "R8", "valid at latency", 64'(rsp_valid), 64'd1);
        chk(rsp_undef == e[65], req, "undef", 64'(rsp_undef), 64'(e[65]));
        chk(rsp_wr_en == e[64], req, "wr_en", 64'(rsp_wr_en), 64'(e[64]));
        chk(rsp_data == e[63:0], req, "data", rsp_data, e[63:0]);
        chk(rsp_dest == w[4:0], "R7", "dest", 64'(rsp_dest), 64'(w[4:0]));
      end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "valid after pulse", 64'(rsp_valid), 64'd0);
  endtask

  logic [63:0] opa [6] = '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                           64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
                           64'hDEAD_BEEF_CAFE_F00D, 64'h1234_5678_8000_0001};
  logic [63:0] opb [6] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                           64'h0000_0000_0000_0002, 64'h0000_0000_FFFF_FFFF,
                           64'h0123_4567_89AB_CDEF, 64'hABCD_EF01_7FFF_FFFF};
  logic [63:0] opc [6] = '{64'h0, 64'h1, 64'h5, 64'h1234,
                           64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_0000_0001};

  task automatic t_reset;
    chk(req_ready == 1'b1, "R10", "ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R10", "valid after reset", 64'(rsp_valid), 64'd0);
    chk(rsp_wr_en == 1'b0, "R10", "wr_en after reset", 64'(rsp_wr_en), 64'd0);
  endtask

  task automatic t_legal;
    logic [6:0] codes [10] = '{7'h00, 7'h01, 7'h40, 7'h41, 7'h42,
                               7'h43, 7'h44, 7'h4A, 7'h4B, 7'h4C};
    string tags [10] = '{"R3", "R3", "R2", "R2", "R4", "R4", "R5", "R4", "R4", "R5"};
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 6; j++)
        run_op(mk(codes[i], 5'd3, 5'd1, 5'd2, 5'd4), opa[j], opb[j], opc[j], tags[i]);
  endtask

  task automatic t_illegal;
    logic [6:0] bad [12] = '{7'h02, 7'h05, 7'h08, 7'h0C, 7'h45, 7'h46,
                             7'h48, 7'h4D, 7'h4E, 7'h7F, 7'h10, 7'h20};
    logic [31:0] w;
    for (int i = 0; i < 12; i++)
      run_op(mk(bad[i], 5'd6, 5'd1, 5'd2, 5'd4), opa[4], opb[4], opc[4], "R1");
    w = mk(7'h40, 5'd6, 5'd1, 5'd2, 5'd4);
    w[24] = 1'b0; // group tag no longer 11011
    run_op(w, opa[5], opb[5], opc[5], "R1");
  endtask

  task automatic t_high_acc_ignored;
    // two accumulator values must give the same upper product
    run_op(mk(7'h44, 5'd7, 5'd1, 5'd2, 5'd4), opa[0], opb[0], 64'hAAAA_5555_AAAA_5555, "R5");
    run_op(mk(7'h4C, 5'd7, 5'd1, 5'd2, 5'd4), opa[1], opb[1], 64'h1357_9BDF_0246_8ACE, "R5");
  endtask

  task automatic t_zero_reg;
    run_op(mk(7'h40, 5'd8, 5'd1, 5'd2, 5'd31), opa[4], opb[4], 64'hFFFF, "R6");
    run_op(mk(7'h41, 5'd8, 5'd31, 5'd2, 5'd4), opa[4], opb[4], opc[4], "R6");
    run_op(mk(7'h42, 5'd8, 5'd1, 5'd31, 5'd4), opa[5], opb[5], opc[5], "R6");
    run_op(mk(7'h00, 5'd8, 5'd1, 5'd2, 5'd31), opa[5], opb[5], opc[5], "R6");
  endtask

  task automatic t_dest31;
    run_op(mk(7'h40, 5'd31, 5'd1, 5'd2, 5'd4), opa[2], opb[2], opc[2], "R7");
    run_op(mk(7'h4C, 5'd31, 5'd1, 5'd2, 5'd4), opa[1], opb[1], opc[1], "R7");
  endtask

  task automatic t_busy_ignore;
    logic [31:0] wa, wb;
    logic [65:0] e;
    wa = mk(7'h40, 5'd9, 5'd1, 5'd2, 5'd4);
    wb = mk(7'h41, 5'd10, 5'd1, 5'd2, 5'd4);
    e  = ref_model(wa, opa[5], opb[5], opc[5]);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_insn = wa;
    req_mul_a = opa[5]; req_mul_b = opb[5]; req_acc = opc[5];
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_insn = wb; req_mul_a = opa[4]; // held valid while not ready
      end
      if (k < LAT)
        chk(req_ready == 1'b0, "R9", "ready while busy", 64'(req_ready), 64'd0);
      else begin
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R8", "valid busy case", 64'(rsp_valid), 64'd1);
        chk(rsp_data == e[63:0], "R9", "first request data", rsp_data, e[63:0]);
        chk(rsp_dest == 5'd9, "R9", "first request dest", 64'(rsp_dest), 64'd9);
        chk(req_ready == 1'b1, "R9", "ready in response cycle", 64'(req_ready), 64'd1);
      end
    end
    for (int k = 0; k < 2 * LAT; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", "no response for ignored request", 64'(rsp_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_legal();
    t_illegal();
    t_high_acc_ignored();
    t_zero_reg();
    t_dest31();
    t_busy_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule